// File: doc/BRIEF.md
# Event Performance Monitor Counter Bank

This block is a bank of hardware activity counters for a chip-level performance monitor. It holds one 64-bit counter that advances once per clock and nine 32-bit general counters. Each general counter picks its input either from a shared set of 64 reference event lines or from one event line wired to that counter alone. An event can be counted by the cycle, by its rising edges, or only when it stays high long enough to meet a programmable threshold.

Counting on every counter can be gated by start and stop triggers taken from four external trigger lines, and it can be held by a local freeze bit. A global freeze bit overrides every local setting. When the top bit of a counter becomes set and that counter's overflow enable is on, an interrupt is raised, subject to a global interrupt enable. Optionally, every counter halts while that interrupt is high. Software reaches all state through a plain word-wide write strobe and a combinational read port.

The register layout, by word address: global control at 0x00; cycle counter low word at 0x01 and high word at 0x02; cycle counter mode word at 0x03 and trigger word at 0x04. General counter n (1 to 9) has its count at 4n+4, its mode word at 4n+5 and its trigger/threshold word at 4n+6. Unmapped addresses read as zero.

Top module: `perf_mon_bank`

## Requirements
- R1: After reset every counter and every local control word reads zero, the global word reads 0x1 (freeze-all set) and `irq` is low.
- R2: A write lands on the next rising clock and takes priority over an increment of the same counter in that cycle; later increments continue from the written value.
- R3: The cycle counter adds one on every clock in which it is not held; its low word at 0x01 carries into its high word at 0x02.
- R4: In a general counter's mode word, bits [13:8] select one of the 64 reference lines; with bit 7 set the counter instead uses its own dedicated event line. With no threshold and bit 2 clear, the counter adds one for each clock in which the chosen line is high.
- R5: With mode bit 2 set and no threshold, a general counter adds one per rising edge (low in one clock, high in the next) of its chosen line.
- R6: With threshold field T (bits [21:16] of the trigger/threshold word) nonzero and multiplier M (bits [26:24]), a general counter adds exactly one for each unbroken high run of its chosen line that lasts at least T·2^M clocks, and nothing for shorter runs.
- R7: With trigger-word bit 0 set, a counter counts only after a rising edge on trigger line [3:2] and stops after a rising edge on trigger line [5:4]; the clock that carries the start edge is not counted, the clock that carries the stop edge is, and a stop edge wins over a start edge in the same clock.
- R8: Mode bit 0 holds its own counter; global bit 0 holds every counter whatever the local bits say.
- R9: Mode bit 1 enables the overflow condition, which is the top bit of the counter (bit 63 for the cycle counter); `irq` is the OR of enabled conditions, gated by global bit 1, and drops once software clears the top bit.
- R10: With global bit 2 set, every counter holds while `irq` is high and resumes when it falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the word at `addr` |
| addr | input | ADDR_W (6) | Word address for writes and reads |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| ref_evt | input | 64 | Shared reference event lines |
| spec_evt | input | NUM_GEN (9) | One dedicated event line per general counter |
| trig | input | 4 | Trigger lines for start/stop control |
| irq | output | 1 | Overflow interrupt |

## Verification
A fault in the event path, such as a wrong select decode, a lost edge history or a run-length register that fails to clear, shows only as a count value that differs from the stimulus history; the bench therefore replays long random event streams and compares the final count read back on the port against a tally built from the same stream. A trigger latch or freeze term stuck in the wrong state shows within one clock as a count that moves when it should hold or stays put when it should move, so directed windows read the counter a known number of clocks after each control change. A broken overflow term reaches `irq` in the same clock that the counter's top bit is written or incremented into place.

// File: rtl/pmu_pkg.sv
// Package: shared field widths, control word types and address helpers
// for the event counter bank. Assumes a 32-bit register bus.
package pmu_pkg;
    localparam int BUS_W  = 32;
    localparam int SEL_W  = 6;
    localparam int THR_W  = 6;
    localparam int MUL_W  = 3;
    localparam int TIDX_W = 2;
    localparam int REF_N  = 1 << SEL_W;
    localparam int TRIG_N = 1 << TIDX_W;
    localparam int RUN_W  = THR_W + (1 << MUL_W) - 1;

    localparam int A_GLOBAL = 0;
    localparam int A_CYC_LO = 1;
    localparam int A_CYC_HI = 2;
    localparam int A_CYC_A  = 3;
    localparam int A_CYC_B  = 4;

    typedef struct packed {
        logic frz;
        logic ovf_en;
    } base_t;

    typedef struct packed {
        base_t              base;
        logic               burst;
        logic               spec;
        logic [SEL_W-1:0]   sel;
    } ctla_t;

    typedef struct packed {
        logic               en;
        logic [TIDX_W-1:0]  start_idx;
        logic [TIDX_W-1:0]  stop_idx;
    } trg_t;

    typedef struct packed {
        trg_t               trg;
        logic [THR_W-1:0]   thr;
        logic [MUL_W-1:0]   mul;
    } ctlb_t;

    // Word address of field off (0 count, 1 mode, 2 trigger) of general counter n (0-based)
    function automatic int gen_addr(input int n, input int off);
        return 4 * n + 8 + off;
    endfunction

    function automatic logic [BUS_W-1:0] base_word(input base_t b);
        logic [BUS_W-1:0] w;
        w = '0;
        w[0] = b.frz;
        w[1] = b.ovf_en;
        return w;
    endfunction

    function automatic logic [BUS_W-1:0] a_word(input ctla_t a);
        logic [BUS_W-1:0] w;
        w = base_word(a.base);
        w[2] = a.burst;
        w[7] = a.spec;
        w[8 +: SEL_W] = a.sel;
        return w;
    endfunction

    function automatic logic [BUS_W-1:0] trg_word(input trg_t t);
        logic [BUS_W-1:0] w;
        w = '0;
        w[0] = t.en;
        w[2 +: TIDX_W] = t.start_idx;
        w[4 +: TIDX_W] = t.stop_idx;
        return w;
    endfunction

    function automatic logic [BUS_W-1:0] b_word(input ctlb_t b);
        logic [BUS_W-1:0] w;
        w = trg_word(b.trg);
        w[16 +: THR_W] = b.thr;
        w[24 +: MUL_W] = b.mul;
        return w;
    endfunction
endpackage

// File: rtl/pmu_evt_qual.sv
// Event qualifier: turns one selected event line into a count pulse.
// Level mode counts high clocks, burst mode counts rising edges, and a
// nonzero threshold counts one pulse per high run reaching thr << mul clocks.
// Assumes the caller gates the pulse with freeze and trigger state.
module pmu_evt_qual
    import pmu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic             burst,
    input  logic [THR_W-1:0] thr,
    input  logic [MUL_W-1:0] mul,
    output logic             hit
);
    logic             evt_q;
    logic [RUN_W-1:0] run_len;
    logic [RUN_W-1:0] need;

    assign need = RUN_W'(thr) << mul;

    // track previous level and length of the current high run (saturating at need)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q   <= 1'b0;
            run_len <= '0;
        end else begin
            evt_q <= evt;
            if (!evt)
                run_len <= '0;
            else if (run_len < need)
                run_len <= run_len + 1'b1;
        end
    end

    // pick the counting rule
    always_comb begin
        if (thr == '0)
            hit = burst ? (evt & ~evt_q) : evt;
        else
            hit = evt && ((run_len + 1'b1) == need);
    end
endmodule

// File: rtl/pmu_trig_gate.sv
// Start/stop gate: when enabled, counting is allowed only between a rising
// edge on the start line and a rising edge on the stop line; stop wins.
// Assumes trig_rise is already a one-clock edge pulse per trigger line.
module pmu_trig_gate
    import pmu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  trg_t              cfg,
    input  logic [TRIG_N-1:0] trig_rise,
    output logic              run
);
    logic armed;
    logic start_hit;
    logic stop_hit;

    assign start_hit = trig_rise[cfg.start_idx];
    assign stop_hit  = trig_rise[cfg.stop_idx];

    // latch the running state from trigger edges
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b0;
        else if (stop_hit)
            armed <= 1'b0;
        else if (start_hit)
            armed <= 1'b1;
    end

    assign run = !cfg.en || armed;
endmodule

// File: rtl/perf_mon_bank.sv
// Top of the counter bank: one free-running 64-bit cycle counter, NUM_GEN
// 32-bit event counters, global control, register read/write and the
// overflow interrupt. Assumes ADDR_W wide enough for gen_addr(NUM_GEN-1, 2).
module perf_mon_bank
    import pmu_pkg::*;
#(
    parameter int NUM_GEN = 9,
    parameter int ADDR_W  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [BUS_W-1:0]   wdata,
    output logic [BUS_W-1:0]   rdata,
    input  logic [REF_N-1:0]   ref_evt,
    input  logic [NUM_GEN-1:0] spec_evt,
    input  logic [TRIG_N-1:0]  trig,
    output logic               irq
);
    localparam int CNT_W = BUS_W;
    localparam int CYC_W = 2 * CNT_W;
    localparam logic [ADDR_W-1:0] AD_GLB = ADDR_W'(A_GLOBAL);
    localparam logic [ADDR_W-1:0] AD_CLO = ADDR_W'(A_CYC_LO);
    localparam logic [ADDR_W-1:0] AD_CHI = ADDR_W'(A_CYC_HI);
    localparam logic [ADDR_W-1:0] AD_CA  = ADDR_W'(A_CYC_A);
    localparam logic [ADDR_W-1:0] AD_CB  = ADDR_W'(A_CYC_B);

    logic                     g_frz, g_irq_en, g_frz_irq;
    logic [CYC_W-1:0]         cyc;
    base_t                    cyc_a;
    trg_t                     cyc_b;
    logic                     cyc_run;
    logic [TRIG_N-1:0]        trig_q, trig_rise;
    logic [NUM_GEN:0]         ovf_vec;
    logic                     hold;
    logic [NUM_GEN*CNT_W-1:0] cnt_flat;
    logic [NUM_GEN*BUS_W-1:0] rd_vec;
    ctla_t                    a_in;
    ctlb_t                    b_in;

    // split the write word into control fields
    always_comb begin
        a_in.base.frz    = wdata[0];
        a_in.base.ovf_en = wdata[1];
        a_in.burst       = wdata[2];
        a_in.spec        = wdata[7];
        a_in.sel         = wdata[8 +: SEL_W];
        b_in.trg.en        = wdata[0];
        b_in.trg.start_idx = wdata[2 +: TIDX_W];
        b_in.trg.stop_idx  = wdata[4 +: TIDX_W];
        b_in.thr           = wdata[16 +: THR_W];
        b_in.mul           = wdata[24 +: MUL_W];
    end

    // global control word: freeze-all, interrupt enable, freeze on interrupt
    always_ff @(posedge clk) begin
        if (!rst_n)
            {g_frz_irq, g_irq_en, g_frz} <= 3'b001;
        else if (wr_en && addr == AD_GLB)
            {g_frz_irq, g_irq_en, g_frz} <= wdata[2:0];
    end

    // trigger edge history
    always_ff @(posedge clk) begin
        if (!rst_n)
            trig_q <= '0;
        else
            trig_q <= trig;
    end
    assign trig_rise = trig & ~trig_q;

    assign ovf_vec[0] = cyc[CYC_W-1] & cyc_a.ovf_en;
    assign irq        = g_irq_en & (|ovf_vec);
    assign hold       = g_frz | (g_frz_irq & irq);

    pmu_trig_gate u_cyc_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (cyc_b),
        .trig_rise (trig_rise),
        .run       (cyc_run)
    );

    // cycle counter control words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_a <= '0;
            cyc_b <= '0;
        end else begin
            if (wr_en && addr == AD_CA) cyc_a <= a_in.base;
            if (wr_en && addr == AD_CB) cyc_b <= b_in.trg;
        end
    end

    // cycle counter: word writes first, then one step per unheld clock
    always_ff @(posedge clk) begin
        if (!rst_n)
            cyc <= '0;
        else if (wr_en && addr == AD_CLO)
            cyc[CNT_W-1:0] <= wdata;
        else if (wr_en && addr == AD_CHI)
            cyc[CYC_W-1:CNT_W] <= wdata;
        else if (!hold && !cyc_a.frz && cyc_run)
            cyc <= cyc + 1'b1;
    end

    for (genvar g = 0; g < NUM_GEN; g++) begin : gen_ctr
        localparam logic [ADDR_W-1:0] AD_C = ADDR_W'(gen_addr(g, 0));
        localparam logic [ADDR_W-1:0] AD_A = ADDR_W'(gen_addr(g, 1));
        localparam logic [ADDR_W-1:0] AD_B = ADDR_W'(gen_addr(g, 2));

        logic [CNT_W-1:0] cnt_r;
        ctla_t            a_r;
        ctlb_t            b_r;
        logic             evt_sel, evt_hit, run_ok;

        assign evt_sel = a_r.spec ? spec_evt[g] : ref_evt[a_r.sel];

        pmu_evt_qual u_qual (
            .clk   (clk),
            .rst_n (rst_n),
            .evt   (evt_sel),
            .burst (a_r.burst),
            .thr   (b_r.thr),
            .mul   (b_r.mul),
            .hit   (evt_hit)
        );

        pmu_trig_gate u_gate (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg       (b_r.trg),
            .trig_rise (trig_rise),
            .run       (run_ok)
        );

        // per-counter control words
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                a_r <= '0;
                b_r <= '0;
            end else begin
                if (wr_en && addr == AD_A) a_r <= a_in;
                if (wr_en && addr == AD_B) b_r <= b_in;
            end
        end

        // event count: write wins over a same-clock increment
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt_r <= '0;
            else if (wr_en && addr == AD_C)
                cnt_r <= wdata;
            else if (!hold && !a_r.base.frz && run_ok && evt_hit)
                cnt_r <= cnt_r + 1'b1;
        end

        assign ovf_vec[g+1]              = cnt_r[CNT_W-1] & a_r.base.ovf_en;
        assign cnt_flat[g*CNT_W +: CNT_W] = cnt_r;
        assign rd_vec[g*BUS_W +: BUS_W]   = (addr == AD_C) ? cnt_r :
                                            (addr == AD_A) ? a_word(a_r) :
                                            (addr == AD_B) ? b_word(b_r) : '0;
    end

    // read mux over global, cycle and general counter words
    always_comb begin
        rdata = '0;
        case (addr)
            AD_GLB: rdata = {{(BUS_W-3){1'b0}}, g_frz_irq, g_irq_en, g_frz};
            AD_CLO: rdata = cyc[CNT_W-1:0];
            AD_CHI: rdata = cyc[CYC_W-1:CNT_W];
            AD_CA:  rdata = base_word(cyc_a);
            AD_CB:  rdata = trg_word(cyc_b);
            default: rdata = '0;
        endcase
        for (int i = 0; i < NUM_GEN; i++)
            rdata = rdata | rd_vec[i*BUS_W +: BUS_W];
    end
endmodule

// File: rtl/perf_mon_chk.sv
// Checker for the counter bank: hold behaviour, write priority, cycle
// counter stepping and interrupt sources. Bound into every perf_mon_bank.
module perf_mon_chk #(
    parameter int NUM_GEN = 9,
    parameter int ADDR_W  = 6,
    parameter int CNT_W   = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_en,
    input logic [ADDR_W-1:0]        addr,
    input logic [CNT_W-1:0]         wdata,
    input logic                     irq,
    input logic                     g_frz,
    input logic                     g_frz_irq,
    input logic [2*CNT_W-1:0]       cyc,
    input logic [NUM_GEN*CNT_W-1:0] cnt_flat
);
    logic [NUM_GEN-1:0] msb_vec;
    for (genvar g = 0; g < NUM_GEN; g++) begin : gen_msb
        assign msb_vec[g] = cnt_flat[g*CNT_W + CNT_W - 1];
    end

    // R8: global freeze with no write keeps every count unchanged
    assert_frz_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (g_frz && !wr_en) |=> ($stable(cnt_flat) && $stable(cyc)));

    // R10: interrupt-driven freeze keeps every count unchanged
    assert_irq_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && g_frz_irq && !wr_en) |=> $stable(cnt_flat));

    // R3: without writes the cycle counter moves by zero or one
    assert_cyc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (cyc == $past(cyc) || cyc == $past(cyc) + 1'b1));

    // R9: the interrupt needs a counter whose top bit is set
    assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cyc[2*CNT_W-1] || (|msb_vec)));

    // R2: a count write lands exactly, regardless of events
    for (genvar g = 0; g < NUM_GEN; g++) begin : gen_wr
        assert_wr_prio_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == ADDR_W'(4 * g + 8)) |=>
            (cnt_flat[g*CNT_W +: CNT_W] == $past(wdata)));
    end
endmodule

bind perf_mon_bank perf_mon_chk #(
    .NUM_GEN (NUM_GEN),
    .ADDR_W  (ADDR_W),
    .CNT_W   (pmu_pkg::BUS_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .irq       (irq),
    .g_frz     (g_frz),
    .g_frz_irq (g_frz_irq),
    .cyc       (cyc),
    .cnt_flat  (cnt_flat)
);

// File: tb/tb_perf_mon_bank.sv
// Bench for perf_mon_bank: seeded random event streams plus directed
// corner cases, compared with tallies computed here from the requirements.
module tb_perf_mon_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [63:0] ref_evt = '0;
    logic [8:0]  spec_evt = '0;
    logic [3:0]  trig = '0;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    perf_mon_bank dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ref_evt(ref_evt), .spec_evt(spec_evt), .trig(trig), .irq(irq)
    );

    function automatic logic [5:0] cnt_a(input int k); return 6'(4 * k + 4); endfunction
    function automatic logic [5:0] mode_a(input int k); return 6'(4 * k + 5); endfunction
    function automatic logic [5:0] trg_a(input int k); return 6'(4 * k + 6); endfunction

    function automatic logic [31:0] mk_mode(input bit frz, input bit ovf, input bit burst,
                                            input bit spec, input int sel);
        return {18'b0, 6'(sel), spec, 4'b0, burst, ovf, frz};
    endfunction

    function automatic logic [31:0] mk_trg(input bit en, input int st, input int sp,
                                           input int thr, input int mul);
        return {5'b0, 3'(mul), 2'b0, 6'(thr), 10'b0, 2'(sp), 2'(st), 1'b0, en};
    endfunction

    function automatic int need_len(input int thr, input int mul);
        return thr << mul;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic pulse(input logic [3:0] lines);
        @(negedge clk); trig = lines;
        @(negedge clk); trig = '0;
    endtask

    // random level stream on one counter; ref line or its own line
    task automatic run_level(input int k, input bit use_spec, input string req);
        int sel;
        int exp;
        logic [31:0] v;
        sel = int'($urandom % 64);
        exp = 0;
        wr(cnt_a(k), 32'd0);
        wr(mode_a(k), mk_mode(0, 0, 0, use_spec, sel));
        wr(6'd0, 32'd0);
        for (int i = 0; i < 200; i++) begin
            ref_evt = {$urandom, $urandom};
            spec_evt = 9'($urandom);
            if (use_spec ? spec_evt[k-1] : ref_evt[sel]) exp++;
            @(negedge clk);
        end
        ref_evt = '0; spec_evt = '0;
        wr(6'd0, 32'd1);
        rd(cnt_a(k), v);
        chk(req, v, 32'(exp));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        int thr, mul, need, len, exp, prev, bit_v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(6'd0, v);  chk("R1 global", v, 32'h1);
        rd(6'd1, v);  chk("R1 cyc lo", v, 32'h0);
        rd(6'd2, v);  chk("R1 cyc hi", v, 32'h0);
        rd(cnt_a(1), v); chk("R1 cnt1", v, 32'h0);
        rd(mode_a(9), v); chk("R1 mode9", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // R3 cycle counter carry: four unheld clocks from 0xFFFFFFFE
        wr(6'd1, 32'hFFFF_FFFE);
        wr(6'd2, 32'h0);
        wr(6'd0, 32'd0);
        repeat (2) @(negedge clk);
        wr(6'd0, 32'd1);
        rd(6'd1, v); chk("R3 cyc lo", v, 32'h2);
        rd(6'd2, v); chk("R3 cyc hi", v, 32'h1);
        wr(6'd3, 32'd1);

        // R2 write priority while the selected event is high every clock
        wr(mode_a(1), mk_mode(0, 0, 0, 0, 5));
        ref_evt[5] = 1'b1;
        wr(6'd0, 32'd0);
        repeat (4) @(negedge clk);
        wr(cnt_a(1), 32'd100);
        rd(cnt_a(1), v); chk("R2 write wins", v, 32'd100);
        repeat (3) @(negedge clk);
        rd(cnt_a(1), v); chk("R2 continue", v, 32'd103);
        ref_evt = '0;
        wr(6'd0, 32'd1);

        // R4 random level counting, reference and dedicated lines
        run_level(2, 1'b0, "R4 ref level");
        run_level(int'(1 + $urandom % 9), 1'b0, "R4 ref level rnd");
        run_level(int'(1 + $urandom % 9), 1'b1, "R4 dedicated line");

        // R5 burst mode: rising edges on ref line 3
        wr(cnt_a(2), 32'd0);
        wr(mode_a(2), mk_mode(0, 0, 1, 0, 3));
        wr(6'd0, 32'd0);
        exp = 0; prev = 0;
        for (int i = 0; i < 120; i++) begin
            bit_v = int'($urandom % 2);
            ref_evt[3] = bit_v[0];
            if (bit_v == 1 && prev == 0) exp++;
            prev = bit_v;
            @(negedge clk);
        end
        ref_evt = '0;
        wr(6'd0, 32'd1);
        rd(cnt_a(2), v); chk("R5 burst edges", v, 32'(exp));

        // R6 threshold runs on ref line 7, including need-1 and need lengths
        thr = int'(1 + $urandom % 7);
        mul = int'($urandom % 3);
        need = need_len(thr, mul);
        wr(cnt_a(3), 32'd0);
        wr(mode_a(3), mk_mode(0, 0, 0, 0, 7));
        wr(trg_a(3), mk_trg(0, 0, 0, thr, mul));
        wr(6'd0, 32'd0);
        exp = 0;
        for (int r = 0; r < 10; r++) begin
            len = (r == 0) ? need - 1 : (r == 1) ? need : int'(1 + $urandom % (2 * need));
            if (len >= need) exp++;
            for (int j = 0; j < len; j++) begin
                ref_evt[7] = 1'b1;
                @(negedge clk);
            end
            ref_evt[7] = 1'b0;
            @(negedge clk);
        end
        wr(6'd0, 32'd1);
        rd(cnt_a(3), v); chk("R6 threshold runs", v, 32'(exp));

        // R7 start/stop triggers: start on line 0, stop on line 1
        wr(cnt_a(4), 32'd0);
        wr(mode_a(4), mk_mode(0, 0, 0, 0, 9));
        wr(trg_a(4), mk_trg(1, 0, 1, 0, 0));
        ref_evt[9] = 1'b1;
        wr(6'd0, 32'd0);
        repeat (5) @(negedge clk);
        rd(cnt_a(4), v); chk("R7 before start", v, 32'd0);
        pulse(4'b0001);
        repeat (3) @(negedge clk);
        pulse(4'b0010);
        repeat (4) @(negedge clk);
        rd(cnt_a(4), v); chk("R7 start to stop", v, 32'd5);
        pulse(4'b0001);
        pulse(4'b0011);
        rd(cnt_a(4), v);
        repeat (4) @(negedge clk);
        rd(cnt_a(4), v2);
        chk("R7 stop wins", v2, 32'd7);
        chk("R7 stays stopped", v2, v);
        ref_evt = '0;
        wr(6'd0, 32'd1);

        // R8 local freeze, then global freeze overriding a clear local bit
        wr(cnt_a(5), 32'd0);
        wr(mode_a(5), mk_mode(1, 0, 0, 0, 11));
        ref_evt[11] = 1'b1;
        wr(6'd0, 32'd0);
        repeat (5) @(negedge clk);
        rd(cnt_a(5), v); chk("R8 local freeze", v, 32'd0);
        wr(6'd0, 32'd1);
        wr(mode_a(5), mk_mode(0, 0, 0, 0, 11));
        repeat (5) @(negedge clk);
        rd(cnt_a(5), v); chk("R8 global override", v, 32'd0);
        wr(6'd0, 32'd0);
        repeat (2) @(negedge clk);
        wr(6'd0, 32'd1);
        rd(cnt_a(5), v); chk("R8 released", v, 32'd4);
        ref_evt = '0;

        // R9 overflow on counter 6 and interrupt gating
        wr(cnt_a(6), 32'h7FFF_FFFF);
        wr(mode_a(6), mk_mode(0, 1, 0, 0, 13));
        wr(6'd0, 32'd0);
        @(negedge clk); ref_evt[13] = 1'b1;
        @(negedge clk); ref_evt[13] = 1'b0;
        rd(cnt_a(6), v); chk("R9 top bit", v, 32'h8000_0000);
        chk("R9 irq gated off", {31'b0, irq}, 32'h0);
        wr(6'd0, 32'd2);
        chk("R9 irq on", {31'b0, irq}, 32'h1);

        // R10 freeze while interrupt is high, resume after clear
        wr(6'd0, 32'd6);
        ref_evt[13] = 1'b1;
        repeat (5) @(negedge clk);
        rd(cnt_a(6), v); chk("R10 held on irq", v, 32'h8000_0000);
        wr(cnt_a(6), 32'd0);
        chk("R9 irq cleared", {31'b0, irq}, 32'h0);
        repeat (3) @(negedge clk);
        rd(cnt_a(6), v); chk("R10 resumed", v, 32'd3);
        ref_evt = '0;
        wr(6'd0, 32'd1);

        // R9 cycle counter overflow on bit 63
        wr(6'd1, 32'hFFFF_FFFF);
        wr(6'd2, 32'h7FFF_FFFF);
        wr(6'd3, 32'd2);
        wr(6'd0, 32'd2);
        wr(6'd0, 32'd3);
        rd(6'd2, v); chk("R9 cyc hi", v, 32'h8000_0000);
        rd(6'd1, v); chk("R3 cyc lo wrap", v, 32'h1);
        chk("R9 cyc irq", {31'b0, irq}, 32'h1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule